// File: doc/BRIEF.md
# 8-bit ALU with Status Register

This block is the arithmetic and logic stage of a small register-register processor. Two 8-bit operands and a 5-bit operation code go in. The 8-bit result leaves combinationally in the same cycle. An 8-bit status register beside the datapath holds the condition flags. The carry-in for the with-carry and rotate operations is taken from that register's carry bit.

Each operation class writes only its own subset of flags and the rest keep their values. This lets software chain multi-byte arithmetic and compares across several instructions. The register loads the new flags on a rising clock edge only while `exec_i` is high, so a stalled pipeline leaves the flags alone.

Status bit layout, MSB to LSB: bit 7 interrupt-enable (I), bit 6 bit-store (T), bit 5 half-carry (H), bit 4 sign (S), bit 3 overflow (V), bit 2 negative (N), bit 1 zero (Z), bit 0 carry (C). Whenever N or V is written, S is written as N xor V. N is always result bit 7.

Top module: `alu8_core`

## Requirements
- R1: After reset `flags_o` is 0x00. No operation ever changes bits 7 (I) and 6 (T), so they stay 0.
- R2: Add (code 0) gives a+b and add-with-carry (code 1) gives a+b+C. Both set C to the carry out of bit 7, H to the carry out of bit 3, V to the signed overflow, and N, Z, S from the result.
- R3: Subtract (2), subtract-with-carry (3), compare (4), compare-with-carry (5) and negate (6) give a−b, a−b−C, a−b, a−b−C and 0−a. Each sets C to the borrow out of bit 7, H to the borrow into bit 4, V to the signed overflow, and N, Z, S.
- R4: For codes 3 and 5, Z is 1 only if the 8-bit result is zero and Z was already 1. A zero result after a nonzero earlier byte leaves Z at 0.
- R5: AND (7), OR (8) and XOR (9) write N, Z and S, and clear V to 0. C and H keep their values.
- R6: One's complement (10) gives 0xFF−a. It sets C to 1 and V to 0, writes N, Z and S, and keeps H.
- R7: Increment (11) and decrement (12) write N, Z and S. V is set only for 0x7F→0x80 (increment) and 0x80→0x7F (decrement). C and H keep their values.
- R8: Shift left (13), logical shift right (14), rotate left through carry (15), rotate right through carry (16) and arithmetic shift right (17) move the outgoing bit into C. The vacated bit gets 0, the old C, or bit 7 (for code 17). V is written as N xor C, N, Z and S are written, and H is kept.
- R9: Nibble swap (18) outputs {a[3:0], a[7:4]} and changes no flag.
- R10: `res_o` depends combinationally on the present inputs and flags. `flags_o` changes only on a clock edge where `exec_i` is 1.
- R11: Codes 19 to 31 output `a_i` unchanged and change no flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| exec_i | input | 1 | Commit the new flags at this edge |
| op_i | input | 5 | Operation code |
| a_i | input | 8 | Destination-side operand |
| b_i | input | 8 | Source-side operand |
| res_o | output | 8 | Combinational result |
| flags_o | output | 8 | Registered status flags |

## Verification
The status register is the only state. A wrong flag value is not visible at the ports in the cycle it is written. It shows up one edge later on `flags_o`, and also in `res_o` of any following operation that consumes the carry. The bench therefore checks the flags right after each commit. It also chains carry and Z across consecutive operations, so that a wrongly kept or wrongly overwritten flag shows up as a wrong result or flag in the next operation.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

    localparam int unsigned DATA_W = 8;
    localparam int unsigned OP_W   = 5;

    // Status bit positions
    localparam int unsigned FB_C = 0;
    localparam int unsigned FB_Z = 1;
    localparam int unsigned FB_N = 2;
    localparam int unsigned FB_V = 3;
    localparam int unsigned FB_S = 4;
    localparam int unsigned FB_H = 5;
    localparam int unsigned FB_T = 6;
    localparam int unsigned FB_I = 7;

    typedef enum logic [OP_W-1:0] {
        OP_ADD  = 5'd0,
        OP_ADC  = 5'd1,
        OP_SUB  = 5'd2,
        OP_SBC  = 5'd3,
        OP_CP   = 5'd4,
        OP_CPC  = 5'd5,
        OP_NEG  = 5'd6,
        OP_AND  = 5'd7,
        OP_OR   = 5'd8,
        OP_XOR  = 5'd9,
        OP_COM  = 5'd10,
        OP_INC  = 5'd11,
        OP_DEC  = 5'd12,
        OP_LSL  = 5'd13,
        OP_LSR  = 5'd14,
        OP_ROL  = 5'd15,
        OP_ROR  = 5'd16,
        OP_ASR  = 5'd17,
        OP_SWAP = 5'd18
    } alu_op_e;

    typedef struct packed {
        logic [DATA_W-1:0] res;
        logic [7:0]        sreg;
    } alu_next_t;

endpackage

// File: rtl/alu8_addsub.sv
module alu8_addsub #(
    parameter int unsigned W   = 8,
    parameter int unsigned NIB = 4
) (
    input  logic [W-1:0] x_i,
    input  logic [W-1:0] y_i,
    input  logic         cin_i,
    input  logic         sub_i,
    output logic [W-1:0] sum_o,
    output logic         c_o,
    output logic         h_o,
    output logic         v_o
);

    logic [W:0]   full;
    logic [NIB:0] low;

    always_comb begin
        if (sub_i) begin
            full = {1'b0, x_i} - {1'b0, y_i} - {{W{1'b0}}, cin_i};
            low  = {1'b0, x_i[NIB-1:0]} - {1'b0, y_i[NIB-1:0]} - {{NIB{1'b0}}, cin_i};
            v_o  = (x_i[W-1] & ~y_i[W-1] & ~full[W-1]) |
                   (~x_i[W-1] & y_i[W-1] & full[W-1]);
        end else begin
            full = {1'b0, x_i} + {1'b0, y_i} + {{W{1'b0}}, cin_i};
            low  = {1'b0, x_i[NIB-1:0]} + {1'b0, y_i[NIB-1:0]} + {{NIB{1'b0}}, cin_i};
            v_o  = (x_i[W-1] & y_i[W-1] & ~full[W-1]) |
                   (~x_i[W-1] & ~y_i[W-1] & full[W-1]);
        end
        sum_o = full[W-1:0];
        c_o   = full[W];
        h_o   = low[NIB];
    end

endmodule

// File: rtl/alu8_bitops.sv
module alu8_bitops
    import alu8_pkg::*;
#(
    parameter int unsigned W = 8
) (
    input  alu_op_e      op_i,
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         cin_i,
    output logic [W-1:0] r_o,
    output logic         c_o
);

    localparam int unsigned HALF = W / 2;

    logic [W-1:0] swapped;

    for (genvar g = 0; g < HALF; g++) begin : g_swap
        assign swapped[g]        = a_i[g + HALF];
        assign swapped[g + HALF] = a_i[g];
    end

    always_comb begin
        r_o = a_i;
        c_o = cin_i;
        unique case (op_i)
            OP_AND:  r_o = a_i & b_i;
            OP_OR:   r_o = a_i | b_i;
            OP_XOR:  r_o = a_i ^ b_i;
            OP_COM: begin
                r_o = ~a_i;
                c_o = 1'b1;
            end
            OP_LSL: begin
                r_o = {a_i[W-2:0], 1'b0};
                c_o = a_i[W-1];
            end
            OP_ROL: begin
                r_o = {a_i[W-2:0], cin_i};
                c_o = a_i[W-1];
            end
            OP_LSR: begin
                r_o = {1'b0, a_i[W-1:1]};
                c_o = a_i[0];
            end
            OP_ROR: begin
                r_o = {cin_i, a_i[W-1:1]};
                c_o = a_i[0];
            end
            OP_ASR: begin
                r_o = {a_i[W-1], a_i[W-1:1]};
                c_o = a_i[0];
            end
            OP_SWAP: r_o = swapped;
            default: ;
        endcase
    end

endmodule

// File: rtl/alu8_core.sv
module alu8_core
    import alu8_pkg::*;
#(
    parameter int unsigned W = DATA_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          exec_i,
    input  logic [OP_W-1:0] op_i,
    input  logic [W-1:0]  a_i,
    input  logic [W-1:0]  b_i,
    output logic [W-1:0]  res_o,
    output logic [7:0]    flags_o
);

    alu_op_e   op;
    logic [7:0] sreg_q;
    alu_next_t nxt_d;

    logic [W-1:0] as_x, as_y, as_sum, bo_r;
    logic         as_cin, as_sub, as_c, as_h, as_v, bo_c;
    logic         carry_q;

    assign op      = alu_op_e'(op_i);
    assign carry_q = sreg_q[FB_C];

    // Operand steering for the shared adder/subtractor
    always_comb begin
        as_x   = a_i;
        as_y   = b_i;
        as_cin = 1'b0;
        as_sub = 1'b0;
        unique case (op)
            OP_ADC: as_cin = carry_q;
            OP_SUB, OP_CP: as_sub = 1'b1;
            OP_SBC, OP_CPC: begin
                as_sub = 1'b1;
                as_cin = carry_q;
            end
            OP_NEG: begin
                as_x   = '0;
                as_y   = a_i;
                as_sub = 1'b1;
            end
            OP_INC: as_y = W'(1);
            OP_DEC: begin
                as_y   = W'(1);
                as_sub = 1'b1;
            end
            default: ;
        endcase
    end

    alu8_addsub #(.W(W), .NIB(4)) u_addsub (
        .x_i   (as_x),
        .y_i   (as_y),
        .cin_i (as_cin),
        .sub_i (as_sub),
        .sum_o (as_sum),
        .c_o   (as_c),
        .h_o   (as_h),
        .v_o   (as_v)
    );

    alu8_bitops #(.W(W)) u_bitops (
        .op_i  (op),
        .a_i   (a_i),
        .b_i   (b_i),
        .cin_i (carry_q),
        .r_o   (bo_r),
        .c_o   (bo_c)
    );

    // Next result and next status value
    always_comb begin
        logic wr_znv, wr_c, wr_h, z_chain;
        logic c_n, h_n, v_n;
        logic [W-1:0] r;
        wr_znv  = 1'b1;
        wr_c    = 1'b0;
        wr_h    = 1'b0;
        z_chain = 1'b0;
        c_n     = as_c;
        h_n     = as_h;
        v_n     = as_v;
        r       = a_i;
        unique case (op)
            OP_ADD, OP_ADC, OP_SUB, OP_CP, OP_NEG: begin
                r = as_sum; wr_c = 1'b1; wr_h = 1'b1;
            end
            OP_SBC, OP_CPC: begin
                r = as_sum; wr_c = 1'b1; wr_h = 1'b1; z_chain = 1'b1;
            end
            OP_AND, OP_OR, OP_XOR: begin
                r = bo_r; v_n = 1'b0;
            end
            OP_COM: begin
                r = bo_r; v_n = 1'b0; c_n = bo_c; wr_c = 1'b1;
            end
            OP_INC, OP_DEC: r = as_sum;
            OP_LSL, OP_LSR, OP_ROL, OP_ROR, OP_ASR: begin
                r = bo_r; c_n = bo_c; wr_c = 1'b1; v_n = bo_r[W-1] ^ bo_c;
            end
            OP_SWAP: begin
                r = bo_r; wr_znv = 1'b0;
            end
            default: wr_znv = 1'b0;
        endcase

        nxt_d.res  = r;
        nxt_d.sreg = sreg_q;
        if (wr_znv) begin
            nxt_d.sreg[FB_N] = r[W-1];
            nxt_d.sreg[FB_V] = v_n;
            nxt_d.sreg[FB_S] = r[W-1] ^ v_n;
            nxt_d.sreg[FB_Z] = (r == '0) & (~z_chain | sreg_q[FB_Z]);
        end
        if (wr_c) nxt_d.sreg[FB_C] = c_n;
        if (wr_h) nxt_d.sreg[FB_H] = h_n;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      sreg_q <= '0;
        else if (exec_i) sreg_q <= nxt_d.sreg;
    end

    assign res_o   = nxt_d.res;
    assign flags_o = sreg_q;

    // R1: interrupt-enable and bit-store flags never move
    p_it_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        sreg_q[FB_I:FB_T] == 2'b00);

    // R10: flags hold when no operation commits
    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !exec_i |=> $stable(sreg_q));

    // R9: nibble swap leaves every flag alone
    p_swap_flags_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_i && op == OP_SWAP) |=> sreg_q == $past(sreg_q));

    // R5: logic ops keep C and H, clear V
    p_logic_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_i && (op == OP_AND || op == OP_OR || op == OP_XOR)) |=>
        (sreg_q[FB_C] == $past(sreg_q[FB_C]) && sreg_q[FB_H] == $past(sreg_q[FB_H])
         && !sreg_q[FB_V]));

    // R7: increment/decrement keep C and H
    p_incdec_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_i && (op == OP_INC || op == OP_DEC)) |=>
        (sreg_q[FB_C] == $past(sreg_q[FB_C]) && sreg_q[FB_H] == $past(sreg_q[FB_H])));

    // R4: a cleared Z stays cleared through a chained subtract or compare
    p_chain_z_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_i && (op == OP_SBC || op == OP_CPC) && !sreg_q[FB_Z]) |=> !sreg_q[FB_Z]);

    // R11: unused codes leave flags alone
    p_unused_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_i && op_i > 5'd18) |=> sreg_q == $past(sreg_q));

endmodule

// File: tb/test_alu8_core.sv
module test_alu8_core;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       exec_i;
    logic [4:0] op_i;
    logic [7:0] a_i, b_i;
    logic [7:0] res_o, flags_o;

    int   n_tests = 0;
    int   n_fail  = 0;
    bit   done    = 1'b0;
    logic [7:0] exp_sreg;

    always #5 clk = ~clk;

    alu8_core i_alu8_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .exec_i  (exec_i),
        .op_i    (op_i),
        .a_i     (a_i),
        .b_i     (b_i),
        .res_o   (res_o),
        .flags_o (flags_o)
    );

    task automatic chk(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %02h expected %02h", req, what, act, exp);
        end
    endtask

    // Behavioural reference built from the requirements with signed/unsigned integers
    function automatic logic [15:0] model(input logic [4:0] op, input logic [7:0] a,
                                          input logic [7:0] b, input logic [7:0] s);
        int ai = int'(a);
        int bi = int'(b);
        int ci = int'(s[0]);
        int sa = (ai > 127) ? ai - 256 : ai;
        int sb = (bi > 127) ? bi - 256 : bi;
        int x, y, sx, sy, cc, r, t;
        bit c = s[0], h = s[5], v = s[3], n = s[2], z = s[1], sf = s[4];
        bit flg = 1'b1;
        logic [7:0] r8;
        r = ai;
        case (op)
            5'd0, 5'd1: begin
                cc = (op == 5'd1) ? ci : 0;
                r = ai + bi + cc;
                c = r > 255;
                h = (ai % 16 + bi % 16 + cc) > 15;
                t = sa + sb + cc;
                v = (t > 127) || (t < -128);
            end
            5'd2, 5'd3, 5'd4, 5'd5, 5'd6: begin
                x = ai; y = bi; sx = sa; sy = sb;
                if (op == 5'd6) begin x = 0; sx = 0; y = ai; sy = sa; end
                cc = (op == 5'd3 || op == 5'd5) ? ci : 0;
                r = x - y - cc;
                c = r < 0;
                h = (x % 16 - y % 16 - cc) < 0;
                t = sx - sy - cc;
                v = (t > 127) || (t < -128);
            end
            5'd7:  begin r = ai & bi; v = 0; end
            5'd8:  begin r = ai | bi; v = 0; end
            5'd9:  begin r = ai ^ bi; v = 0; end
            5'd10: begin r = 255 - ai; c = 1; v = 0; end
            5'd11: begin r = ai + 1; v = (ai == 127); end
            5'd12: begin r = ai - 1; v = (ai == 128); end
            5'd13: begin r = ai * 2; c = ai >= 128; end
            5'd14: begin r = ai / 2; c = ai % 2; end
            5'd15: begin r = ai * 2 + ci; c = ai >= 128; end
            5'd16: begin r = ai / 2 + 128 * ci; c = ai % 2; end
            5'd17: begin r = ai / 2 + ((ai >= 128) ? 128 : 0); c = ai % 2; end
            5'd18: begin r = (ai % 16) * 16 + ai / 16; flg = 0; end
            default: begin r = ai; flg = 0; end
        endcase
        r8 = 8'(r & 255);
        if (flg) begin
            n = r8[7];
            z = (r8 == 8'h00);
            if (op == 5'd3 || op == 5'd5) z = z && s[1];
            if (op >= 5'd13 && op <= 5'd17) v = n ^ c;
            sf = n ^ v;
        end
        return {r8, s[7:6], h, sf, v, n, z, c};
    endfunction

    task automatic run_op(input logic [4:0] op, input logic [7:0] a, input logic [7:0] b,
                          input logic ex, input string req);
        logic [15:0] m;
        m = model(op, a, b, exp_sreg);
        @(negedge clk);
        op_i = op; a_i = a; b_i = b; exec_i = ex;
        #1;
        chk(req, "result", res_o, m[15:8]);
        @(negedge clk);
        exec_i = 1'b0;
        if (ex) exp_sreg = m[7:0];
        chk(req, "flags", flags_o, exp_sreg);
    endtask

    task automatic t_reset();
        rst_n = 1'b0; exec_i = 1'b0; op_i = 5'd0; a_i = 8'h03; b_i = 8'h04;
        exp_sreg = 8'h00;
        repeat (3) @(negedge clk);
        chk("R1", "reset flags", flags_o, 8'h00);
        chk("R10", "comb result", res_o, 8'h07);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_add();
        run_op(5'd0, 8'h7F, 8'h01, 1'b1, "R2");
        chk("R2", "overflow flags literal", flags_o, 8'h2C);
        run_op(5'd0, 8'hFF, 8'h01, 1'b1, "R2");
        run_op(5'd1, 8'h10, 8'h20, 1'b1, "R2");
        run_op(5'd1, 8'h8F, 8'h80, 1'b1, "R2");
    endtask

    task automatic t_sub();
        run_op(5'd2, 8'h10, 8'h20, 1'b1, "R3");
        run_op(5'd2, 8'h80, 8'h01, 1'b1, "R3");
        run_op(5'd4, 8'h05, 8'h05, 1'b1, "R3");
        run_op(5'd6, 8'h00, 8'h00, 1'b1, "R3");
        run_op(5'd6, 8'h80, 8'h00, 1'b1, "R3");
        run_op(5'd3, 8'h20, 8'h0F, 1'b1, "R3");
    endtask

    task automatic t_chain();
        run_op(5'd4, 8'h34, 8'h12, 1'b1, "R4");
        run_op(5'd5, 8'h12, 8'h12, 1'b1, "R4");
        chk("R4", "Z after nonzero low byte", {7'd0, flags_o[1]}, 8'h00);
        run_op(5'd4, 8'h05, 8'h05, 1'b1, "R4");
        run_op(5'd5, 8'h07, 8'h07, 1'b1, "R4");
        chk("R4", "Z after equal bytes", {7'd0, flags_o[1]}, 8'h01);
        run_op(5'd4, 8'h00, 8'h01, 1'b1, "R4");
        run_op(5'd3, 8'h01, 8'h00, 1'b1, "R4");
    endtask

    task automatic t_logic();
        run_op(5'd2, 8'h00, 8'h01, 1'b1, "R5");
        run_op(5'd7, 8'hF0, 8'h0F, 1'b1, "R5");
        run_op(5'd8, 8'h80, 8'h01, 1'b1, "R5");
        run_op(5'd9, 8'hAA, 8'hAA, 1'b1, "R5");
        run_op(5'd10, 8'h55, 8'h00, 1'b1, "R6");
        run_op(5'd10, 8'hFF, 8'h00, 1'b1, "R6");
    endtask

    task automatic t_incdec();
        run_op(5'd11, 8'h7F, 8'h00, 1'b1, "R7");
        run_op(5'd12, 8'h80, 8'h00, 1'b1, "R7");
        run_op(5'd2, 8'h00, 8'h01, 1'b1, "R7");
        run_op(5'd11, 8'hFF, 8'h00, 1'b1, "R7");
        run_op(5'd12, 8'h00, 8'h00, 1'b1, "R7");
    endtask

    task automatic t_shift();
        run_op(5'd13, 8'h81, 8'h00, 1'b1, "R8");
        run_op(5'd15, 8'h40, 8'h00, 1'b1, "R8");
        run_op(5'd14, 8'h01, 8'h00, 1'b1, "R8");
        run_op(5'd16, 8'h02, 8'h00, 1'b1, "R8");
        run_op(5'd16, 8'h03, 8'h00, 1'b1, "R8");
        run_op(5'd16, 8'h00, 8'h00, 1'b1, "R8");
        run_op(5'd17, 8'h81, 8'h00, 1'b1, "R8");
    endtask

    task automatic t_misc();
        run_op(5'd18, 8'h3C, 8'h00, 1'b1, "R9");
        run_op(5'd0, 8'hFF, 8'h01, 1'b0, "R10");
        run_op(5'd25, 8'h5A, 8'h77, 1'b1, "R11");
        run_op(5'd31, 8'h00, 8'hFF, 1'b1, "R11");
        chk("R1", "I and T bits", {6'd0, flags_o[7:6]}, 8'h00);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    initial begin
        #1_000_000;
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        t_reset();
        t_add();
        t_sub();
        t_chain();
        t_logic();
        t_incdec();
        t_shift();
        t_misc();
        finish_run();
    end

endmodule